// File: doc/BRIEF.md
# Segmented Operand Address Generator

This block computes where a memory operand lives for a 16-bit processor with segmented memory. The addressing mode is already decoded when it arrives. The block receives the mode together with the base and index pointer values, a displacement, and the four segment register values. From these it forms a 16-bit offset and chooses which segment to use. It then produces the 20-bit physical address by shifting the segment value left by four bits and adding the offset.

The caller presents a request together with a one-cycle strobe. One clock later the offset, the segment code and the physical address appear on registered outputs, and a valid flag pulses for that single cycle. Between requests the result outputs keep their last values. Segment selection is made in this order, highest priority first:
1. A string-destination request always uses the extra segment.
2. An explicit override selects the segment named by the override.
3. Otherwise the default applies: any form that uses BP goes to the stack segment, and every other form goes to the data segment.

Top module: `seg_addr_gen`

## Requirements
- R1: While reset is high and after it is released, before any strobe arrives, `valid_o`, `ea_o`, `seg_o` and `phys_o` all read zero.
- R2: `valid_o` is high in the cycle after each cycle in which `strobe_i` is high. It is low in every other cycle.
- R3: Mode code 0 (direct) gives an offset equal to the full 16-bit `disp_i`. This ignores `disp_wide_i`. The default segment is DS.
- R4: Mode code 1 (single pointer) gives an offset equal to the pointer chosen by `one_reg_i`, with codes 0=BX, 1=BP, 2=SI, 3=DI.
- R5: Mode code 2 (single pointer plus displacement) adds the displacement to the chosen pointer. When `disp_wide_i`=0 the displacement is `disp_i[7:0]` sign-extended to 16 bits. When `disp_wide_i`=1 it is the full `disp_i`.
- R6: Mode code 3 (base plus index) gives base + index. The base is BX when `base_sel_i`=0 and BP when it is 1. The index is SI when `idx_sel_i`=0 and DI when it is 1.
- R7: Mode code 4 (base plus index plus displacement) gives base + index + displacement, where the displacement is formed as in R5.
- R8: All offset arithmetic wraps modulo 2^16.
- R9: With no override and no string destination, the segment code is SS (2) whenever BP is the chosen pointer or base. In every other case it is DS (3). Segment codes are 0=ES, 1=CS, 2=SS, 3=DS.
- R10: When `ovr_en_i`=1 and `str_dst_i`=0, the segment code equals `ovr_seg_i`, whatever the default would have been.
- R11: When `str_dst_i`=1, the segment code is ES (0). This holds even when an override is present.
- R12: `phys_o` equals (selected segment value × 16) + `ea_o`, wrapping modulo 2^20.
- R13: In cycles that follow a cycle without a strobe, `ea_o`, `seg_o` and `phys_o` keep their previous values, even when the inputs change.
- R14: Mode codes 5, 6 and 7 behave exactly like mode code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| strobe_i | input | 1 | Request strobe; inputs are sampled on this cycle |
| mode_i | input | 3 | Decoded addressing mode code |
| one_reg_i | input | 2 | Pointer choice for single-pointer modes |
| base_sel_i | input | 1 | Base choice: 0 BX, 1 BP |
| idx_sel_i | input | 1 | Index choice: 0 SI, 1 DI |
| disp_i | input | 16 | Displacement or direct offset |
| disp_wide_i | input | 1 | 1 = 16-bit displacement, 0 = sign-extended low byte |
| bx_i | input | 16 | BX value |
| bp_i | input | 16 | BP value |
| si_i | input | 16 | SI value |
| di_i | input | 16 | DI value |
| es_i | input | 16 | ES value |
| cs_i | input | 16 | CS value |
| ss_i | input | 16 | SS value |
| ds_i | input | 16 | DS value |
| ovr_en_i | input | 1 | Segment override present |
| ovr_seg_i | input | 2 | Override segment code |
| str_dst_i | input | 1 | String destination access |
| valid_o | output | 1 | One-cycle result pulse |
| ea_o | output | 16 | Effective offset |
| seg_o | output | 2 | Selected segment code |
| phys_o | output | 20 | Physical address |

## Verification
Several properties are checked on every cycle against the inputs sampled one cycle earlier:
- the valid pulse follows the strobe;
- the results hold between requests;
- the string-destination and override priorities are respected;
- the BP-to-SS default applies to base-plus-index forms;
- the base-plus-index sum is correct;
- the physical address equals the shifted segment plus the offset.

Other behaviours can only be shown by the directed scenarios with known pointer values. These are sign extension of a negative short displacement, wrap of the 16-bit and 20-bit sums, every mode code including the reserved ones, and the reset values.

// File: rtl/seg_addr_pkg.sv
package seg_addr_pkg;

    localparam int unsigned OFS_W     = 16;
    localparam int unsigned SEG_SHIFT = 4;
    localparam int unsigned PHYS_W    = OFS_W + SEG_SHIFT;

    typedef enum logic [2:0] {
        AM_DIRECT       = 3'd0,
        AM_ONE_REG      = 3'd1,
        AM_ONE_REG_DISP = 3'd2,
        AM_PAIR         = 3'd3,
        AM_PAIR_DISP    = 3'd4
    } amode_e;

    typedef enum logic [1:0] {
        SEG_ES = 2'd0,
        SEG_CS = 2'd1,
        SEG_SS = 2'd2,
        SEG_DS = 2'd3
    } seg_e;

    typedef struct packed {
        logic [OFS_W-1:0] bx;
        logic [OFS_W-1:0] bp;
        logic [OFS_W-1:0] si;
        logic [OFS_W-1:0] di;
    } ptr_set_t;

    typedef struct packed {
        logic [OFS_W-1:0] es;
        logic [OFS_W-1:0] cs;
        logic [OFS_W-1:0] ss;
        logic [OFS_W-1:0] ds;
    } seg_set_t;

    typedef struct packed {
        logic              valid;
        logic [OFS_W-1:0]  ea;
        seg_e              seg;
        logic [PHYS_W-1:0] phys;
    } addr_res_t;

    function automatic logic [OFS_W-1:0] seg_value(seg_e code, seg_set_t s);
        case (code)
            SEG_ES:  return s.es;
            SEG_CS:  return s.cs;
            SEG_SS:  return s.ss;
            default: return s.ds;
        endcase
    endfunction

    function automatic logic is_one_reg(logic [2:0] m);
        return (m == AM_ONE_REG) || (m == AM_ONE_REG_DISP);
    endfunction

    function automatic logic is_pair(logic [2:0] m);
        return (m == AM_PAIR) || (m == AM_PAIR_DISP);
    endfunction

endpackage

// File: rtl/ea_calc.sv
module ea_calc
    import seg_addr_pkg::*;
#(
    parameter int unsigned W = OFS_W
) (
    input  logic [2:0]   mode,
    input  logic [1:0]   one_reg,
    input  logic         base_sel,
    input  logic         idx_sel,
    input  logic [W-1:0] disp,
    input  logic         disp_wide,
    input  logic [W-1:0] bx,
    input  logic [W-1:0] bp,
    input  logic [W-1:0] si,
    input  logic [W-1:0] di,
    output logic [W-1:0] ea,
    output logic         uses_bp
);
    logic [W-1:0] disp_ext;
    logic [W-1:0] single_ptr;
    logic [W-1:0] base_val;
    logic [W-1:0] idx_val;
    logic [W-1:0] add_disp;

    always_comb begin
        disp_ext = disp_wide ? disp : {{(W-8){disp[7]}}, disp[7:0]};

        case (one_reg)
            2'd0:    single_ptr = bx;
            2'd1:    single_ptr = bp;
            2'd2:    single_ptr = si;
            default: single_ptr = di;
        endcase

        base_val = base_sel ? bp : bx;
        idx_val  = idx_sel  ? di : si;

        if ((mode == AM_ONE_REG_DISP) || (mode == AM_PAIR_DISP)) begin
            add_disp = disp_ext;
        end else begin
            add_disp = '0;
        end

        if (is_pair(mode)) begin
            ea = base_val + idx_val + add_disp;
        end else if (is_one_reg(mode)) begin
            ea = single_ptr + add_disp;
        end else begin
            ea = disp;
        end

        uses_bp = (is_pair(mode) && base_sel) ||
                  (is_one_reg(mode) && (one_reg == 2'd1));
    end
endmodule

// File: rtl/seg_select.sv
module seg_select
    import seg_addr_pkg::*;
(
    input  logic       uses_bp,
    input  logic       ovr_en,
    input  logic [1:0] ovr_seg,
    input  logic       str_dst,
    output seg_e       seg
);
    always_comb begin
        if (str_dst) begin
            seg = SEG_ES;
        end else if (ovr_en) begin
            seg = seg_e'(ovr_seg);
        end else if (uses_bp) begin
            seg = SEG_SS;
        end else begin
            seg = SEG_DS;
        end
    end
endmodule

// File: rtl/phys_calc.sv
module phys_calc #(
    parameter int unsigned W  = 16,
    parameter int unsigned SH = 4,
    localparam int unsigned PW = W + SH
) (
    input  logic [W-1:0]  seg_val,
    input  logic [W-1:0]  ofs,
    output logic [PW-1:0] phys
);
    logic [PW-1:0] seg_shifted;
    logic [PW-1:0] ofs_ext;

    always_comb begin
        seg_shifted = {seg_val, {SH{1'b0}}};
        ofs_ext     = {{SH{1'b0}}, ofs};
        phys        = seg_shifted + ofs_ext;
    end
endmodule

// File: rtl/seg_addr_gen.sv
module seg_addr_gen
    import seg_addr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              strobe_i,
    input  logic [2:0]        mode_i,
    input  logic [1:0]        one_reg_i,
    input  logic              base_sel_i,
    input  logic              idx_sel_i,
    input  logic [OFS_W-1:0]  disp_i,
    input  logic              disp_wide_i,
    input  logic [OFS_W-1:0]  bx_i,
    input  logic [OFS_W-1:0]  bp_i,
    input  logic [OFS_W-1:0]  si_i,
    input  logic [OFS_W-1:0]  di_i,
    input  logic [OFS_W-1:0]  es_i,
    input  logic [OFS_W-1:0]  cs_i,
    input  logic [OFS_W-1:0]  ss_i,
    input  logic [OFS_W-1:0]  ds_i,
    input  logic              ovr_en_i,
    input  logic [1:0]        ovr_seg_i,
    input  logic              str_dst_i,
    output logic              valid_o,
    output logic [OFS_W-1:0]  ea_o,
    output logic [1:0]        seg_o,
    output logic [PHYS_W-1:0] phys_o
);
    ptr_set_t          ptrs;
    seg_set_t          segs;
    logic [OFS_W-1:0]  ea_c;
    logic              uses_bp_c;
    seg_e              seg_c;
    logic [OFS_W-1:0]  seg_val_c;
    logic [PHYS_W-1:0] phys_c;
    addr_res_t         res_q;

    assign ptrs = '{bx: bx_i, bp: bp_i, si: si_i, di: di_i};
    assign segs = '{es: es_i, cs: cs_i, ss: ss_i, ds: ds_i};

    ea_calc #(.W(OFS_W)) u_ea (
        .mode      (mode_i),
        .one_reg   (one_reg_i),
        .base_sel  (base_sel_i),
        .idx_sel   (idx_sel_i),
        .disp      (disp_i),
        .disp_wide (disp_wide_i),
        .bx        (ptrs.bx),
        .bp        (ptrs.bp),
        .si        (ptrs.si),
        .di        (ptrs.di),
        .ea        (ea_c),
        .uses_bp   (uses_bp_c)
    );

    seg_select u_seg (
        .uses_bp (uses_bp_c),
        .ovr_en  (ovr_en_i),
        .ovr_seg (ovr_seg_i),
        .str_dst (str_dst_i),
        .seg     (seg_c)
    );

    assign seg_val_c = seg_value(seg_c, segs);

    phys_calc #(.W(OFS_W), .SH(SEG_SHIFT)) u_phys (
        .seg_val (seg_val_c),
        .ofs     (ea_c),
        .phys    (phys_c)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q <= '0;
        end else begin
            res_q.valid <= strobe_i;
            if (strobe_i) begin
                res_q.ea   <= ea_c;
                res_q.seg  <= seg_c;
                res_q.phys <= phys_c;
            end
        end
    end

    assign valid_o = res_q.valid;
    assign ea_o    = res_q.ea;
    assign seg_o   = res_q.seg;
    assign phys_o  = res_q.phys;

    // R2: pulse follows strobe by one cycle
    p_valid_follows_r2: assert property (@(posedge clk) disable iff (rst)
        valid_o == ($past(strobe_i) && !$past(rst)));

    // R13: results hold when no request was taken
    p_hold_idle_r13: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(strobe_i)) |->
            ($stable(ea_o) && $stable(seg_o) && $stable(phys_o)));

    // R11: string destination wins over everything
    p_strdst_es_r11: assert property (@(posedge clk) disable iff (rst)
        (valid_o && $past(str_dst_i)) |-> (seg_o == SEG_ES));

    // R10: override replaces the default
    p_override_r10: assert property (@(posedge clk) disable iff (rst)
        (valid_o && $past(ovr_en_i) && !$past(str_dst_i)) |->
            (seg_o == $past(ovr_seg_i)));

    // R9: BP base with no override goes to the stack segment
    p_bp_stack_r9: assert property (@(posedge clk) disable iff (rst)
        (valid_o && !$past(ovr_en_i) && !$past(str_dst_i) &&
         ($past(mode_i) == AM_PAIR) && $past(base_sel_i)) |->
            (seg_o == SEG_SS));

    // R6: base plus index sum
    p_pair_sum_r6: assert property (@(posedge clk) disable iff (rst)
        (valid_o && ($past(mode_i) == AM_PAIR)) |->
            (ea_o == OFS_W'($past(base_sel_i ? bp_i : bx_i) +
                            $past(idx_sel_i ? di_i : si_i))));

    // R12: physical address composition
    p_phys_form_r12: assert property (@(posedge clk) disable iff (rst)
        valid_o |-> (phys_o == PHYS_W'({$past(seg_value(seg_c, segs)), {SEG_SHIFT{1'b0}}} +
                                       {{SEG_SHIFT{1'b0}}, ea_o})));
endmodule

// File: tb/seg_addr_gen_tb.sv
module seg_addr_gen_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        strobe_i;
    logic [2:0]  mode_i;
    logic [1:0]  one_reg_i;
    logic        base_sel_i, idx_sel_i;
    logic [15:0] disp_i;
    logic        disp_wide_i;
    logic [15:0] bx_i, bp_i, si_i, di_i;
    logic [15:0] es_i, cs_i, ss_i, ds_i;
    logic        ovr_en_i;
    logic [1:0]  ovr_seg_i;
    logic        str_dst_i;
    logic        valid_o;
    logic [15:0] ea_o;
    logic [1:0]  seg_o;
    logic [19:0] phys_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #5 clk = ~clk;

    seg_addr_gen dut_i (
        .clk(clk), .rst(rst), .strobe_i(strobe_i), .mode_i(mode_i),
        .one_reg_i(one_reg_i), .base_sel_i(base_sel_i), .idx_sel_i(idx_sel_i),
        .disp_i(disp_i), .disp_wide_i(disp_wide_i),
        .bx_i(bx_i), .bp_i(bp_i), .si_i(si_i), .di_i(di_i),
        .es_i(es_i), .cs_i(cs_i), .ss_i(ss_i), .ds_i(ds_i),
        .ovr_en_i(ovr_en_i), .ovr_seg_i(ovr_seg_i), .str_dst_i(str_dst_i),
        .valid_o(valid_o), .ea_o(ea_o), .seg_o(seg_o), .phys_o(phys_o)
    );

    function automatic logic [15:0] seg_of(logic [1:0] c);
        case (c)
            2'd0:    return es_i;
            2'd1:    return cs_i;
            2'd2:    return ss_i;
            default: return ds_i;
        endcase
    endfunction

    function automatic logic [19:0] form_phys(logic [15:0] s, logic [15:0] o);
        return 20'(({4'h0, s} << 4) + {4'h0, o});
    endfunction

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic set_defaults();
        strobe_i = 0; mode_i = 3'd0; one_reg_i = 2'd0; base_sel_i = 0; idx_sel_i = 0;
        disp_i = 16'h0; disp_wide_i = 1; ovr_en_i = 0; ovr_seg_i = 2'd0; str_dst_i = 0;
        bx_i = 16'h1234; bp_i = 16'h2000; si_i = 16'h0010; di_i = 16'h0F00;
        es_i = 16'h1000; cs_i = 16'h2000; ss_i = 16'h3000; ds_i = 16'h4000;
    endtask

    // Pulse strobe for one cycle, then check results one cycle later.
    task automatic issue(string req, logic [15:0] exp_ea, logic [1:0] exp_seg);
        strobe_i = 1;
        @(negedge clk);
        strobe_i = 0;
        check(req, "valid", 32'(valid_o), 32'd1);
        check(req, "ea", 32'(ea_o), 32'(exp_ea));
        check(req, "seg", 32'(seg_o), 32'(exp_seg));
        check(req, "phys", 32'(phys_o), 32'(form_phys(seg_of(exp_seg), exp_ea)));
    endtask

    task automatic t_reset();
        check("R1", "valid", 32'(valid_o), 0);
        check("R1", "ea", 32'(ea_o), 0);
        check("R1", "seg", 32'(seg_o), 0);
        check("R1", "phys", 32'(phys_o), 0);
    endtask

    task automatic t_direct();
        set_defaults(); mode_i = 3'd0; disp_i = 16'h5000; disp_wide_i = 0;
        issue("R3", 16'h5000, 2'd3);
        check("R12", "phys direct", 32'(phys_o), 32'h45000);
    endtask

    task automatic t_single();
        set_defaults(); mode_i = 3'd1; one_reg_i = 2'd0; issue("R4", 16'h1234, 2'd3);
        set_defaults(); mode_i = 3'd1; one_reg_i = 2'd1; issue("R9", 16'h2000, 2'd2);
        check("R12", "phys bp", 32'(phys_o), 32'h32000);
        set_defaults(); mode_i = 3'd1; one_reg_i = 2'd3; issue("R4", 16'h0F00, 2'd3);
    endtask

    task automatic t_single_disp();
        set_defaults(); mode_i = 3'd2; one_reg_i = 2'd2; disp_i = 16'h1280; disp_wide_i = 0;
        issue("R5", 16'hFF90, 2'd3);
        set_defaults(); mode_i = 3'd2; one_reg_i = 2'd2; disp_i = 16'h0080; disp_wide_i = 1;
        issue("R5", 16'h0090, 2'd3);
    endtask

    task automatic t_pair();
        set_defaults(); mode_i = 3'd3; issue("R6", 16'h1244, 2'd3);
        set_defaults(); mode_i = 3'd3; base_sel_i = 1; idx_sel_i = 1; issue("R9", 16'h2F00, 2'd2);
        set_defaults(); mode_i = 3'd4; idx_sel_i = 1; disp_i = 16'hAA50; disp_wide_i = 0;
        issue("R7", 16'h2184, 2'd3);
    endtask

    task automatic t_wrap();
        set_defaults(); mode_i = 3'd4; base_sel_i = 1; idx_sel_i = 1; disp_i = 16'hF000;
        issue("R8", 16'h1F00, 2'd2);
        check("R8", "phys", 32'(phys_o), 32'h31F00);
        set_defaults(); ds_i = 16'hFFFF; mode_i = 3'd0; disp_i = 16'h0020;
        issue("R12", 16'h0020, 2'd3);
        check("R12", "phys wrap", 32'(phys_o), 32'h00010);
    endtask

    task automatic t_override();
        set_defaults(); mode_i = 3'd1; one_reg_i = 2'd1; ovr_en_i = 1; ovr_seg_i = 2'd0;
        issue("R10", 16'h2000, 2'd0);
        check("R10", "phys", 32'(phys_o), 32'h12000);
        set_defaults(); mode_i = 3'd3; ovr_en_i = 1; ovr_seg_i = 2'd1; str_dst_i = 1;
        issue("R11", 16'h1244, 2'd0);
    endtask

    task automatic t_hold_and_pulse();
        set_defaults(); mode_i = 3'd3; issue("R2", 16'h1244, 2'd3);
        mode_i = 3'd1; one_reg_i = 2'd1; ovr_en_i = 1; ovr_seg_i = 2'd1; bp_i = 16'hBEEF;
        @(negedge clk);
        check("R2", "valid low", 32'(valid_o), 0);
        @(negedge clk);
        check("R13", "ea held", 32'(ea_o), 32'h1244);
        check("R13", "seg held", 32'(seg_o), 32'd3);
        check("R13", "phys held", 32'(phys_o), 32'h41244);
    endtask

    task automatic t_reserved();
        for (int m = 5; m < 8; m++) begin
            set_defaults(); mode_i = 3'(m); one_reg_i = 2'd1; base_sel_i = 1; disp_i = 16'h0777;
            issue("R14", 16'h0777, 2'd3);
        end
    endtask

    initial begin
        set_defaults();
        rst = 1;
        repeat (3) @(negedge clk);
        t_reset();
        rst = 0;
        @(negedge clk);
        t_reset();
        t_direct();
        t_single();
        t_single_disp();
        t_pair();
        t_wrap();
        t_override();
        t_hold_and_pulse();
        t_reserved();
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                n_checks++; n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule